// File: doc/BRIEF.md
# Interrupt Capability Configuration Registers

This block holds the configuration-space capability structure of a table-based message interrupt function. The bus decoder passes it configuration accesses that already fall inside the capability window. Each access is a byte offset inside the capability, a length code and write data. Reads are combinational and return one, two or four bytes, least significant byte first. Writes are screened byte by byte, so the only state that software can change is the function enable bit and the function mask bit.

The identity, the next pointer, the vector count, the BAR index and the table and pending-array locators are fixed at elaboration. The block brings out the enable, the mask and the table size to the vector table logic. It also drives a one-cycle rescan request when a write may have released held-back vectors. A write releases them by turning the function on or by removing the function mask. The vector count must lie in 1..1024, the BAR index in 0..5 and the next pointer below 0xFF. Any other value stops elaboration.

Top module: `msix_cap_regs`

## Requirements
- R1: After reset, fn_enable_o, fn_mask_o and rescan_o are 0.
- R2: Byte offset 0 reads 0x11 and byte offset 1 reads the NEXT_PTR parameter. Writes to either byte leave the read value unchanged.
- R3: Message control (byte offsets 2..3) holds NUM_VECTORS-1 in bits [9:0], with bits [13:10] zero. table_size_o equals bits [9:0] plus one. No write changes bits [13:0].
- R4: Bit 15 of message control (bit 7 of byte offset 3) is the function enable and bit 14 (bit 6 of byte offset 3) is the function mask. A write that covers offset 3 loads both bits. The new values show on fn_enable_o, fn_mask_o and in reads from the cycle after the write edge onward.
- R5: The dword at byte offsets 4..7 reads BAR_IDX. The dword at offsets 8..11 reads 0x800 | BAR_IDX. Writes do not change them.
- R6: A write puts data byte k (bits [8k+7:8k]) at byte offset addr+k, for k below the access length. Lanes whose target lies past offset 11 are dropped.
- R7: Length code 0 reads one byte, code 1 reads two bytes, and codes 2 and 3 read four bytes. Byte k of cfg_rdata_o comes from offset addr+k. Unused lanes and offsets past 11 read 0.
- R8: A write that moves the mask bit from 1 to 0 raises rescan_o for exactly the one cycle after the write edge.
- R9: A write that moves the enable bit from 0 to 1 also raises rescan_o for one cycle. A write that does both raises a single one-cycle pulse.
- R10: rescan_o stays 0 when no write happens, and after a write that neither clears the mask nor sets the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe for the current access |
| cfg_addr_i | input | 4 | Byte offset inside the capability |
| cfg_len_i | input | 2 | Access length code: 0 byte, 1 word, 2/3 dword |
| cfg_wdata_i | input | 32 | Write data, lane 0 in bits [7:0] |
| cfg_rdata_o | output | 32 | Read data for offset and length |
| fn_enable_o | output | 1 | Function enable bit |
| fn_mask_o | output | 1 | Function mask bit |
| table_size_o | output | 11 | Number of table entries |
| rescan_o | output | 1 | One-cycle request to rescan pending vectors |

## Verification
The two events that can fall on the same write are clearing the mask and setting the enable. A single write lands on byte offset 3, either as a byte access or as a wider access from a lower offset. The bench prepares the state with enable=0 and mask=1, then writes 0b10 into the top two bits. It requires one rescan cycle, followed by a low rescan_o on the next cycle. Random writes with random prior states cover the same case, and the bench model predicts the pulse from the old and new bit values.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;
  localparam int unsigned CAP_BYTES   = 12;
  localparam int unsigned CTRL_HI_OFF = 3;
  localparam logic [7:0]  CAP_ID      = 8'h11;
  localparam logic [31:0] PBA_OFFSET  = 32'h0000_0800;
  localparam logic [31:0] TBL_OFFSET  = 32'h0000_0000;

  typedef enum logic [1:0] {
    LEN_BYTE = 2'b00,
    LEN_WORD = 2'b01,
    LEN_DW   = 2'b10,
    LEN_DW_A = 2'b11
  } acc_len_e;

  function automatic int unsigned len_bytes(input logic [1:0] code);
    case (acc_len_e'(code))
      LEN_BYTE: return 1;
      LEN_WORD: return 2;
      default:  return 4;
    endcase
  endfunction
endpackage

// File: rtl/msix_cap_ctrl.sv
module msix_cap_ctrl
  import msix_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        len_i,
  input  logic [31:0]       wdata_i,
  output logic              en_o,
  output logic              mask_o,
  output logic              rescan_o
);
  logic en_q, mask_q, rescan_q;
  logic en_d, mask_d, rescan_d;

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    for (int k = 0; k < 4; k++) begin
      if (wr_i && (k < int'(len_bytes(len_i))) &&
          (int'(addr_i) + k == int'(CTRL_HI_OFF))) begin
        en_d   = wdata_i[8*k+7];
        mask_d = wdata_i[8*k+6];
      end
    end
    // one pulse whatever the number of release causes
    rescan_d = (mask_q & ~mask_d) | (~en_q & en_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      rescan_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      mask_q   <= mask_d;
      rescan_q <= rescan_d;
    end
  end

  assign en_o     = en_q;
  assign mask_o   = mask_q;
  assign rescan_o = rescan_q;

  // R4
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(en_q) && $stable(mask_q)));
  // R8
  mask_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mask_q) |-> rescan_q);
  // R9
  enable_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> rescan_q);
  // R10
  rescan_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rescan_q |-> ($fell(mask_q) || $rose(en_q)));
  // R10
  rescan_needs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rescan_q |-> $past(wr_i));
endmodule

// File: rtl/msix_cap_read.sv
module msix_cap_read
  import msix_cap_pkg::*;
#(
  parameter int unsigned NUM_VECTORS = 16,
  parameter int unsigned BAR_IDX     = 2,
  parameter int unsigned NEXT_PTR    = 8'h40,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        len_i,
  input  logic              en_i,
  input  logic              mask_i,
  output logic [31:0]       rdata_o
);
  localparam logic [9:0]  CNT_FIELD = 10'(NUM_VECTORS - 1);
  localparam logic [31:0] TBL_DW    = TBL_OFFSET | 32'(BAR_IDX);
  localparam logic [31:0] PBA_DW    = PBA_OFFSET | 32'(BAR_IDX);

  logic [7:0] img [CAP_BYTES];

  always_comb begin
    img[0]  = CAP_ID;
    img[1]  = 8'(NEXT_PTR);
    img[2]  = CNT_FIELD[7:0];
    img[3]  = {en_i, mask_i, 4'b0000, CNT_FIELD[9:8]};
    for (int b = 0; b < 4; b++) begin
      img[4+b] = TBL_DW[8*b +: 8];
      img[8+b] = PBA_DW[8*b +: 8];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < 4; k++) begin
      if ((k < int'(len_bytes(len_i))) && (int'(addr_i) + k < int'(CAP_BYTES)))
        rdata_o[8*k +: 8] = img[int'(addr_i) + k];
    end
  end
endmodule

// File: rtl/msix_cap_regs.sv
module msix_cap_regs
  import msix_cap_pkg::*;
#(
  parameter int unsigned NUM_VECTORS = 16,
  parameter int unsigned BAR_IDX     = 2,
  parameter int unsigned NEXT_PTR    = 8'h40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_wr_i,
  input  logic [3:0]  cfg_addr_i,
  input  logic [1:0]  cfg_len_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  output logic        fn_enable_o,
  output logic        fn_mask_o,
  output logic [10:0] table_size_o,
  output logic        rescan_o
);
  localparam int unsigned ADDR_W    = 4;
  localparam logic [9:0]  CNT_FIELD = 10'(NUM_VECTORS - 1);

  generate
    if (NUM_VECTORS < 1 || NUM_VECTORS > 1024) begin : g_bad_count
      $error("vector count out of range 1..1024");
    end
    if (BAR_IDX > 5) begin : g_bad_bar
      $error("BAR index above 5");
    end
    if (NEXT_PTR >= 8'hFF) begin : g_bad_next
      $error("next pointer must be below 0xFF");
    end
  endgenerate

  msix_cap_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr_i),
    .addr_i   (cfg_addr_i),
    .len_i    (cfg_len_i),
    .wdata_i  (cfg_wdata_i),
    .en_o     (fn_enable_o),
    .mask_o   (fn_mask_o),
    .rescan_o (rescan_o)
  );

  msix_cap_read #(
    .NUM_VECTORS (NUM_VECTORS),
    .BAR_IDX     (BAR_IDX),
    .NEXT_PTR    (NEXT_PTR),
    .ADDR_W      (ADDR_W)
  ) i_read (
    .addr_i  (cfg_addr_i),
    .len_i   (cfg_len_i),
    .en_i    (fn_enable_o),
    .mask_i  (fn_mask_o),
    .rdata_o (cfg_rdata_o)
  );

  assign table_size_o = {1'b0, CNT_FIELD} + 11'd1;

  // R3
  table_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (table_size_o != 11'd0) && (table_size_o <= 11'd1024));
  // R7
  rdata_byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_len_i == 2'b00) |-> (cfg_rdata_o[31:8] == 24'd0));
  // R7
  rdata_word_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_len_i == 2'b01) |-> (cfg_rdata_o[31:16] == 16'd0));
endmodule

// File: tb/test_msix_cap_regs.sv
module test_msix_cap_regs;
  localparam int unsigned NV   = 16;
  localparam int unsigned BAR  = 2;
  localparam int unsigned NXT  = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  len = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        en, mask, rescan;
  logic [10:0] tsize;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit m_en = 1'b0, m_mask = 1'b0;

  always #5 clk = ~clk;

  msix_cap_regs #(.NUM_VECTORS(NV), .BAR_IDX(BAR), .NEXT_PTR(NXT)) i_msix_cap_regs (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_len_i(len),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .fn_enable_o(en), .fn_mask_o(mask),
    .table_size_o(tsize), .rescan_o(rescan)
  );

  function automatic int nbytes(logic [1:0] l);
    return (l == 2'd0) ? 1 : (l == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] exp_byte(int t, bit e, bit m);
    logic [9:0] cnt;
    cnt = 10'(NV - 1);
    case (t)
      0: return 8'h11;
      1: return 8'(NXT);
      2: return cnt[7:0];
      3: return {e, m, 4'b0, cnt[9:8]};
      4: return 8'(BAR);
      8: return 8'(BAR);
      9: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a, logic [1:0] l, bit e, bit m);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < nbytes(l); k++)
      if (int'(a) + k < 12) r[8*k +: 8] = exp_byte(int'(a) + k, e, m);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns expected rescan and updates model
  task automatic do_write(logic [3:0] a, logic [1:0] l, logic [31:0] d, string req);
    bit ne, nm, rs;
    ne = m_en; nm = m_mask;
    for (int k = 0; k < nbytes(l); k++)
      if (int'(a) + k == 3) begin ne = d[8*k+7]; nm = d[8*k+6]; end
    rs = (m_mask && !nm) || (!m_en && ne);
    @(negedge clk);
    wr = 1'b1; addr = a; len = l; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    m_en = ne; m_mask = nm;
    check({req, " enable"}, {31'b0, en}, {31'b0, m_en});
    check({req, " mask"}, {31'b0, mask}, {31'b0, m_mask});
    check({req, " rescan"}, {31'b0, rescan}, {31'b0, rs});
  endtask

  task automatic do_read(logic [3:0] a, logic [1:0] l, string req);
    @(negedge clk);
    addr = a; len = l;
    #1;
    check(req, rdata, exp_read(a, l, m_en, m_mask));
  endtask

  task automatic idle_rescan_low(string req);
    @(negedge clk);
    check(req, {31'b0, rescan}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    check("R1 enable", {31'b0, en}, 32'd0);
    check("R1 mask", {31'b0, mask}, 32'd0);
    check("R1 rescan", {31'b0, rescan}, 32'd0);
    // R2 / R3 / R5 / R7
    do_read(4'd0, 2'd0, "R2 id");
    do_read(4'd1, 2'd0, "R2 next");
    do_read(4'd0, 2'd2, "R7 dword at 0");
    do_read(4'd2, 2'd1, "R3 ctrl word");
    check("R3 table size", {21'b0, tsize}, NV);
    do_read(4'd4, 2'd2, "R5 table dword");
    do_read(4'd8, 2'd2, "R5 pending dword");
    do_read(4'd10, 2'd2, "R7 dword past end");
    // R2 / R5 read-only bytes: all ones everywhere except offset 3
    do_write(4'd0, 2'd1, 32'hFFFF, "R2 write id");
    do_read(4'd0, 2'd1, "R2 after write");
    do_write(4'd4, 2'd2, 32'hFFFF_FFFF, "R5 write table");
    do_write(4'd8, 2'd2, 32'hFFFF_FFFF, "R5 write pending");
    do_read(4'd4, 2'd2, "R5 table after write");
    do_read(4'd8, 2'd2, "R5 pending after write");
    // R4 / R3: byte write at 3 sets mask only, low bits stay
    do_write(4'd3, 2'd0, 32'h0000_007F, "R4 set mask");
    do_read(4'd2, 2'd1, "R3 low bits held");
    do_write(4'd2, 2'd0, 32'h0000_00FF, "R3 low byte write");
    do_read(4'd2, 2'd1, "R3 low byte ignored");
    // R8: clear mask
    do_write(4'd3, 2'd0, 32'h0, "R8 clear mask");
    idle_rescan_low("R8 single cycle");
    // R9: enable rise via dword at 0 (lane 3 -> bits 31:30)
    do_write(4'd0, 2'd2, 32'h8000_0000, "R9 enable via lane3");
    idle_rescan_low("R9 single cycle");
    // R10: rewrite same, clear enable, set mask
    do_write(4'd2, 2'd1, 32'h8000, "R10 same value");
    do_write(4'd3, 2'd0, 32'h40, "R10 disable and mask");
    // R9: both causes at once, word at 2 (lane 1)
    do_write(4'd2, 2'd1, 32'h0000_8000, "R9 both causes");
    idle_rescan_low("R9 one pulse");
    // R6: dword at 1, lane 2 lands on offset 3
    do_write(4'd3, 2'd0, 32'h40, "R6 prep");
    do_write(4'd1, 2'd2, 32'h0080_0000, "R6 lane2 to offset3");
    do_read(4'd2, 2'd1, "R6 readback");
    // R6: lanes past end dropped
    do_write(4'd11, 2'd2, 32'hFFFF_FFFF, "R6 past end");
    // R10 idle
    repeat (3) idle_rescan_low("R10 idle");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  ra;
      logic [1:0]  rl;
      logic [31:0] rd;
      ra = 4'($urandom_range(0, 15));
      rl = 2'($urandom_range(0, 3));
      rd = $urandom;
      if ($urandom_range(0, 1) == 0) do_write(ra, rl, rd, "R6 R8 R9 R10 random write");
      else do_read(ra, rl, "R7 random read");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule